// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a behavioural model of a flash memory's write-cycle command interpreter. It watches single-cycle bus writes (address plus data byte), recognises multi-write unlock sequences, and turns them into word programming, chip erase, or entry into and exit from a fast-program mode. In the fast mode, programming needs two writes instead of four. A busy counter stands in for the internal program and erase algorithms. While that counter runs, the block drives its ready output low and returns a status byte on reads in place of array data.

A small internal byte array holds the stored contents. Programming can only clear bits. Chip erase returns every bit to one. An active-low hardware reset aborts any running operation and drops back to read mode without touching the array. An accelerate input, while held high and the block is ready, forces the block straight into the fast-program mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: A standard program is four writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then the target address and data. Any write that breaks a sequence returns the block to read mode.
- R2: The writes AAh at 555h, 55h at 2AAh and 20h at 555h enter fast-program mode. In that mode, a write with data A0h (any address) followed by an address/data write programs one word, and the pair may repeat.
- R3: In fast-program mode, a write whose data is neither A0h nor 90h has no effect, and the block stays in fast-program mode.
- R4: In fast-program mode, a write with data 90h followed by a write with data 00h returns the block to read mode, where an A0h/data pair no longer programs.
- R5: Chip erase is six writes: AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, 10h at 555h. ERASE_CYCLES clock cycles later, every word reads FFh.
- R6: `ready` is 1 after reset. It is 0 for exactly PROG_CYCLES (or ERASE_CYCLES) cycles, starting with the cycle after the accepting write. Writes made while `ready` is 0 are ignored.
- R7: While busy, `dataOut` is a status byte. Bit 7 is the complement of bit 7 of the data being programmed, and 0 during erase. Bit 6 starts at 0 when an operation starts and inverts after every cycle with `rdEn` high. Bits 5..0 are 0.
- R8: A program stores the old word ANDed with the written data, so no bit rises from 0 to 1.
- R9: `rstN` low aborts a running operation. The target word stays unchanged, `ready` returns to 1, and the block is in read mode.
- R10: While the block is ready, `accel` high puts it in fast-program mode, so an A0h/data pair programs at once. Mode exit is ignored while `accel` stays high.
- R11: When ready, `dataOut` shows the array word selected by `addr[ARR_AW-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Write cycle strobe |
| rdEn | input | 1 | Read cycle strobe (advances the toggle bit while busy) |
| addr | input | ADDR_W | Bus address for reads and writes |
| dataIn | input | 8 | Write data |
| accel | input | 1 | Accelerate: forces fast-program mode |
| dataOut | output | 8 | Array word or status byte |
| ready | output | 1 | 1 when no operation is running |

## Verification
A wrong sequence state first shows as a missing or extra busy window. One cycle after the final write of a sequence, `ready` either fails to fall or falls when it should not, so a per-clock comparison of `ready` catches a decoding fault within one cycle of the offending write. Errors in the array update or the status byte appear on `dataOut`. The status byte is compared on every busy cycle, and a stored word is compared the first cycle it is addressed after the busy window ends.

// File: rtl/fcsi_pkg.sv
package fcsi_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PROG,
    S_ERA1,
    S_ERA2,
    S_ERA3,
    S_BYP,
    S_BYP_PROG,
    S_BYP_EXIT
  } seqState_t;

  typedef struct packed {
    logic busy;
    logic opErase;
    logic progStart;
    logic eraseStart;
    logic progDone;
    logic eraseDone;
  } strobe_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_FASTIN  = 8'h20;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_FASTEX1 = 8'h90;
  localparam logic [7:0] OP_FASTEX2 = 8'h00;

endpackage

// File: rtl/fcsi_ctrl.sv
module fcsi_ctrl
  import fcsi_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              accel,
  output strobe_t           strb
);

  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] ADDR_KEY1 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADDR_KEY2 = ADDR_W'(12'h2AA);

  seqState_t stateQ, stateEff, stateNxt;
  logic [CNT_W-1:0] cntQ;
  logic opEraseQ;
  logic busy, finishing, progStart, eraseStart;
  logic isKey1, isKey2, atCmd, stateIsByp;

  assign busy      = (cntQ != '0);
  assign finishing = (cntQ == CNT_W'(1));
  assign isKey1    = (wrAddr == ADDR_KEY1) && (wrData == KEY_FIRST);
  assign isKey2    = (wrAddr == ADDR_KEY2) && (wrData == KEY_SECOND);
  assign atCmd     = (wrAddr == ADDR_KEY1);
  assign stateIsByp = (stateQ == S_BYP) || (stateQ == S_BYP_PROG) || (stateQ == S_BYP_EXIT);

  // accelerate overrides any standard-mode state while ready
  always_comb begin
    stateEff = stateQ;
    if (accel && !busy && !stateIsByp) stateEff = S_BYP;
  end

  always_comb begin
    stateNxt   = stateEff;
    progStart  = 1'b0;
    eraseStart = 1'b0;
    if (busy) begin
      stateNxt = stateQ;
    end else if (wrEn) begin
      case (stateEff)
        S_IDLE: stateNxt = isKey1 ? S_UNL1 : S_IDLE;
        S_UNL1: stateNxt = isKey2 ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          if (atCmd && wrData == OP_PROGRAM)     stateNxt = S_PROG;
          else if (atCmd && wrData == OP_ERASE)  stateNxt = S_ERA1;
          else if (atCmd && wrData == OP_FASTIN) stateNxt = S_BYP;
          else                                   stateNxt = S_IDLE;
        end
        S_PROG: begin
          progStart = 1'b1;
          stateNxt  = S_IDLE;
        end
        S_ERA1: stateNxt = isKey1 ? S_ERA2 : S_IDLE;
        S_ERA2: stateNxt = isKey2 ? S_ERA3 : S_IDLE;
        S_ERA3: begin
          eraseStart = atCmd && (wrData == OP_CHIP);
          stateNxt   = S_IDLE;
        end
        S_BYP: begin
          if (wrData == OP_PROGRAM)      stateNxt = S_BYP_PROG;
          else if (wrData == OP_FASTEX1) stateNxt = S_BYP_EXIT;
          else                           stateNxt = S_BYP;
        end
        S_BYP_PROG: begin
          progStart = 1'b1;
          stateNxt  = S_BYP;
        end
        S_BYP_EXIT: begin
          if (wrData == OP_FASTEX2 && !accel) stateNxt = S_IDLE;
          else                                stateNxt = S_BYP;
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      cntQ     <= '0;
      opEraseQ <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      if (progStart) begin
        cntQ     <= CNT_W'(PROG_CYCLES);
        opEraseQ <= 1'b0;
      end else if (eraseStart) begin
        cntQ     <= CNT_W'(ERASE_CYCLES);
        opEraseQ <= 1'b1;
      end else if (busy) begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  assign strb.busy       = busy;
  assign strb.opErase    = opEraseQ;
  assign strb.progStart  = progStart;
  assign strb.eraseStart = eraseStart;
  assign strb.progDone   = finishing && !opEraseQ;
  assign strb.eraseDone  = finishing && opEraseQ;

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(stateQ)); // R6
  AST_ACCEL_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (accel && !busy) |=> stateIsByp); // R10
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (progStart || eraseStart) |=> busy); // R6
  AST_ERASE_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (stateQ == S_ERA3)); // R5

endmodule

// File: rtl/fcsi_data.sv
module fcsi_data
  import fcsi_pkg::*;
#(
  parameter int ARR_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ARR_AW-1:0] wordAddr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [DEPTH-1:0][7:0] memQ;
  logic [ARR_AW-1:0] latAddrQ;
  logic [7:0] latDataQ;
  logic togQ;
  logic [7:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddrQ <= '0;
      latDataQ <= '0;
      togQ     <= 1'b0;
    end else begin
      if (strb.progStart) begin
        latAddrQ <= wordAddr;
        latDataQ <= wrData;
      end else if (strb.progDone) begin
        latAddrQ <= '0;
        latDataQ <= '0;
      end
      if (strb.progStart || strb.eraseStart) togQ <= 1'b0;
      else if (strb.busy && rdEn)             togQ <= ~togQ;
    end
  end

  // array is non-volatile: untouched by reset
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (strb.eraseDone)
        memQ[w] <= 8'hFF;
      else if (strb.progDone && latAddrQ == ARR_AW'(w))
        memQ[w] <= memQ[w] & latDataQ;
    end
  end

  assign statusByte = {(strb.opErase ? 1'b0 : ~latDataQ[7]), togQ, 6'b0};
  assign rdData     = strb.busy ? statusByte : memQ[wordAddr];

  AST_PROG_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.progDone |=> ((memQ[$past(latAddrQ)] & ~$past(memQ[latAddrQ])) == 8'h00)); // R8
  AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseDone |=> (memQ == '1)); // R5
  AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && rdEn && !strb.progStart && !strb.eraseStart) |=> (togQ != $past(togQ))); // R7

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcsi_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int ARR_AW       = 4,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              accel,
  output logic [7:0]        dataOut,
  output logic              ready
);

  strobe_t strb;

  fcsi_ctrl #(
    .ADDR_W(ADDR_W),
    .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .wrAddr(addr),
    .wrData(dataIn),
    .accel(accel),
    .strb(strb)
  );

  fcsi_data #(
    .ARR_AW(ARR_AW)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wordAddr(addr[ARR_AW-1:0]),
    .wrData(dataIn),
    .rdEn(rdEn),
    .rdData(dataOut)
  );

  assign ready = ~strb.busy;

  AST_READY_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (dataOut[5:0] == 6'b0)); // R7

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int ARR_AW = 4;
  localparam int DEPTH = 1 << ARR_AW;
  localparam int PROG_N = 6;
  localparam int ERASE_N = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, accel = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic ready;

  int nCmp = 0, nBad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N))
    u_flash_cmd_seq (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
                     .dataIn(dataIn), .accel(accel), .dataOut(dataOut), .ready(ready));

  // behavioural reference model
  logic [7:0] mMem [DEPTH];
  bit   [DEPTH-1:0] mKnown = '0;
  int   mPhase = 0, mLeft = 0, mFastSub = 0;
  bit   mFast = 0, mErasing = 0, mTog = 0;
  int   mTgt = 0;
  logic [7:0] mVal = '0;

  task automatic mStartProg(input int a, input logic [7:0] d);
    mTgt = a % DEPTH; mVal = d; mLeft = PROG_N; mErasing = 0; mTog = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mFast = 0; mFastSub = 0; mTog = 0;
    end else if (mLeft > 0) begin
      if (rdEn) mTog = !mTog;
      mLeft--;
      if (mLeft == 0) begin
        if (mErasing) begin
          foreach (mMem[i]) mMem[i] = 8'hFF;
          mKnown = '1;
        end else begin
          mMem[mTgt] = mMem[mTgt] & mVal;
        end
      end
    end else begin
      if (accel && !mFast) begin mFast = 1; mFastSub = 0; end
      if (wrEn) begin
        int a; int d;
        a = int'(addr); d = int'(dataIn);
        if (mFast) begin
          case (mFastSub)
            0: mFastSub = (d == 'hA0) ? 1 : (d == 'h90) ? 2 : 0;
            1: begin mStartProg(a, dataIn); mFastSub = 0; end
            default: begin
              if (d == 0 && !accel) begin mFast = 0; mPhase = 0; end
              mFastSub = 0;
            end
          endcase
        end else begin
          case (mPhase)
            0, 4: mPhase = (a == 'h555 && d == 'hAA) ? mPhase + 1 : 0;
            1, 5: mPhase = (a == 'h2AA && d == 'h55) ? mPhase + 1 : 0;
            2: begin
              if (a == 'h555 && d == 'hA0) mPhase = 3;
              else if (a == 'h555 && d == 'h80) mPhase = 4;
              else if (a == 'h555 && d == 'h20) begin mPhase = 0; mFast = 1; mFastSub = 0; end
              else mPhase = 0;
            end
            3: begin mStartProg(a, dataIn); mPhase = 0; end
            default: begin
              if (a == 'h555 && d == 'h10) begin mLeft = ERASE_N; mErasing = 1; mTog = 0; end
              mPhase = 0;
            end
          endcase
        end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    logic expRdy; logic [7:0] expOut; int w;
    expRdy = (mLeft == 0);
    nCmp++;
    if (ready !== expRdy) begin
      nBad++;
      $display("FAIL R6 ready at cycle %0d: got %b expected %b", cyc, ready, expRdy);
    end
    w = int'(addr) % DEPTH;
    if (!expRdy) begin
      expOut = {(mErasing ? 1'b0 : ~mVal[7]), mTog, 6'b0};
      nCmp++;
      if (dataOut !== expOut) begin
        nBad++;
        $display("FAIL R7 status at cycle %0d: got %h expected %h", cyc, dataOut, expOut);
      end
    end else if (mKnown[w]) begin
      expOut = mMem[w];
      nCmp++;
      if (dataOut !== expOut) begin
        nBad++;
        $display("FAIL R11 word %0d at cycle %0d: got %h expected %h", w, cyc, dataOut, expOut);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1; wrEn = 1; addr = ADDR_W'(a); dataIn = 8'(d);
    @(posedge clk); #1; wrEn = 0;
  endtask

  task automatic rd(input int a);
    @(posedge clk); #1; rdEn = 1; addr = ADDR_W'(a);
    @(posedge clk); #1; rdEn = 0;
  endtask

  task automatic settle(input bit pollReads);
    for (int i = 0; i < 200 && mLeft > 0; i++) begin
      @(posedge clk); #1; rdEn = pollReads;
    end
    @(posedge clk); #1; rdEn = 0;
  endtask

  task automatic sweep();
    for (int i = 0; i < DEPTH; i++) rd(i);
  endtask

  task automatic unlock();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  task automatic chipErase();
    unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nBad++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    // reset state: ready high (R6)
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    repeat (2) @(posedge clk);

    // R5 chip erase, polled with toggle reads (R7, bit7 = 0)
    chipErase(); settle(1); sweep();

    // R1 standard program, R6 busy window, R7 toggle polling
    unlock(); wr('h555, 'hA0); wr(3, 'h5A); settle(1); rd(3);
    // R8 AND semantics: 5A & A5 = 00
    unlock(); wr('h555, 'hA0); wr(3, 'hA5); settle(0); rd(3);
    // R6 writes during busy ignored
    unlock(); wr('h555, 'hA0); wr(4, 'h0F);
    unlock(); wr('h555, 'hA0); wr(5, 'h00);
    settle(1); sweep();
    // R1 broken sequence does nothing
    wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr(6, 'h00); rd(6);
    unlock(); wr('h555, 'h77); wr('h555, 'hA0); wr(6, 'h00); rd(6);

    // R2 fast mode entry and repeated two-write programs
    unlock(); wr('h555, 'h20);
    wr('h000, 'hA0); wr(7, 'h0F); settle(0);
    wr('h3FF, 'hA0); wr(8, 'hF0); settle(1);
    // R3 stray writes ignored in fast mode
    wr('h555, 'hAA); wr('h2AA, 'h55); wr(9, 'h77); rd(9);
    wr('h000, 'hA0); wr(9, 'h7E); settle(0); rd(9);
    // R4 exit, then A0/data pair no longer programs
    wr('h000, 'h90); wr('h000, 'h00);
    wr('h000, 'hA0); wr(10, 'h00); rd(10); sweep();

    // R9 reset aborts a running program
    unlock(); wr('h555, 'hA0); wr(11, 'h00);
    repeat (2) @(posedge clk);
    #1 rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    rd(11); wr('h000, 'hA0); wr(11, 'h00); rd(11);

    // R10 accelerate forces fast mode; exit ignored while held
    @(posedge clk); #1 accel = 1;
    wr('h000, 'hA0); wr(12, 'h12); settle(1);
    wr('h000, 'h90); wr('h000, 'h00);
    wr('h000, 'hA0); wr(13, 'h81); settle(0);
    @(posedge clk); #1 accel = 0;
    wr('h000, 'h90); wr('h000, 'h00);
    wr('h000, 'hA0); wr(14, 'h00); sweep();

    // R5 second erase restores all ones; R11 sweep
    chipErase(); settle(1); sweep();

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule